// File: doc/BRIEF.md
# Scatter-Gather Bus-Master DMA Engine

This block moves a disk channel's data between a device byte stream and system memory. It follows a list of region descriptors that software places in memory. Each descriptor is 8 bytes long and is read as two 32-bit words. The first word is the region's base address. The low half of the second word is the region's byte count, and bit 31 of the second word marks the final descriptor. Software programs the table address, clears stale status, then writes the command register to start the engine. When the flagged region completes, the engine raises an interrupt. Software acknowledges it by writing one to the status bit.

A single memory request port serves both descriptor fetches and data beats. A descriptor fetch is a 32-bit word read with `mem_word` high. A data beat is a one-byte access at a byte address. The port has a request/acknowledge handshake with an error flag. In the device-to-memory direction, bytes from `dev_in_*` become memory writes. In the other direction, memory reads are forwarded on `dev_out_*`. Each beat completes in the cycle that `mem_ack` is seen.

Register window (`reg_addr`):

- 0: command. Bit 0 is start. Bit 3 is direction, where 1 means device to memory.
- 1: status. Bit 0 is busy. Bit 1 is error. Bit 2 is interrupt.
- 2: table pointer.

Reads are combinational.

Top module: `prd_dma_engine`

## Requirements
- R1: Descriptors are fetched as two word reads (`mem_word`=1, `mem_we`=0), first at the table pointer and then at pointer+4. The next descriptor is fetched at pointer+8. The low 2 bits of any value written to the pointer register are forced to zero.
- R2: A byte count field of 0 in bits 15:0 of the second descriptor word denotes a region of 65536 bytes.
- R3: With command bit 3 set, each byte accepted on `dev_in` is written to memory at consecutive byte addresses starting from the region base. With bit 3 clear, bytes read from consecutive addresses are presented on `dev_out` in address order.
- R4: After the last byte of a region whose descriptor has bit 31 of its second word set, the engine does three things. It sets status bit 2 and drives `irq` high while that bit is set. It clears status bit 0. It then issues no further memory requests.
- R5: A command write with bit 0 clear stops the engine. From the next cycle on there are no memory requests, status bit 0 is clear, and no interrupt is raised.
- R6: Writing 1 to status bit 1 or bit 2 clears that bit. Writing 0 to either bit leaves it unchanged.
- R7: `mem_req` is never high while `bm_en` is low. A stalled transfer resumes and completes once `bm_en` returns high.
- R8: A memory response with `mem_err` set halts the transfer, sets status bit 1 and clears status bit 0. The failed beat is not counted as transferred.
- R9: A `dev_done` pulse while the engine is busy sets status bit 1 and halts the transfer.
- R10: After reset all registers read 0 and `irq` is low. A transfer starts only on a command write whose bit 0 goes from 0 to 1. Rewriting start while it is already set has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bm_en | input | 1 | Bus-master permission |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_word | output | 1 | Request is a 32-bit descriptor fetch |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | Request completes this cycle |
| mem_err | input | 1 | Completion carries an error |
| mem_rdata | input | 32 | Read data |
| dev_in_valid | input | 1 | Device byte available |
| dev_in_data | input | 8 | Device byte |
| dev_in_ready | output | 1 | Device byte consumed |
| dev_out_valid | output | 1 | Byte toward device valid |
| dev_out_data | output | 8 | Byte toward device |
| dev_out_ready | input | 1 | Device can accept a byte |
| dev_done | input | 1 | Device reports completion |
| irq | output | 1 | Interrupt |

## Verification
A wrong region pointer or byte counter shows up in the same cycle as a wrong `mem_addr` on a data beat. It also shows up, one region later, as a wrong total beat count. A wrong end-of-table flag shows as a surplus descriptor fetch at pointer+8 or as a missing interrupt after the final beat. A stuck busy state shows at the ports as requests continuing in the cycle after a stop write or an error response, or as status bit 0 still reading 1.

// File: rtl/prd_dma_engine.sv
module prd_dma_engine (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bm_en,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic        mem_word,
  output logic [31:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic        mem_ack,
  input  logic        mem_err,
  input  logic [31:0] mem_rdata,
  input  logic        dev_in_valid,
  input  logic [7:0]  dev_in_data,
  output logic        dev_in_ready,
  output logic        dev_out_valid,
  output logic [7:0]  dev_out_data,
  input  logic        dev_out_ready,
  input  logic        dev_done,
  output logic        irq
);
  typedef enum logic [1:0] {S_IDLE, S_FD0, S_FD1, S_XFER} st_t;
  st_t         st;
  logic        cmd_start, cmd_dir, st_err, st_int, last_rgn;
  logic [31:0] tbl_ptr, dptr, cur;
  logic [16:0] left;

  wire cmd_wr = reg_wr && reg_addr == 2'd0;
  wire go     = cmd_wr && reg_wdata[0] && !cmd_start;
  wire halt   = cmd_wr && !reg_wdata[0];
  wire fetch  = st == S_FD0 || st == S_FD1;
  wire xfer   = st == S_XFER;
  wire busy   = st != S_IDLE;
  wire beat   = mem_req && mem_ack;
  wire ok     = beat && !mem_err;

  assign mem_word      = fetch;
  assign mem_req       = bm_en && (fetch || (xfer && (cmd_dir ? dev_in_valid : dev_out_ready)));
  assign mem_we        = xfer && cmd_dir;
  assign mem_addr      = fetch ? dptr + ((st == S_FD1) ? 32'd4 : 32'd0) : cur;
  assign mem_wdata     = dev_in_data;
  assign dev_in_ready  = xfer && cmd_dir && ok;
  assign dev_out_valid = xfer && !cmd_dir && ok;
  assign dev_out_data  = mem_rdata[7:0];
  assign irq           = st_int;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {28'd0, cmd_dir, 2'b00, cmd_start};
      2'd1:    reg_rdata = {29'd0, st_int, st_err, busy};
      2'd2:    reg_rdata = tbl_ptr;
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cmd_start <= 1'b0;
      cmd_dir <= 1'b0;
      st_err <= 1'b0;
      st_int <= 1'b0;
      last_rgn <= 1'b0;
      tbl_ptr <= '0;
      dptr <= '0;
      cur <= '0;
      left <= '0;
    end else begin
      if (cmd_wr) begin
        cmd_start <= reg_wdata[0];
        cmd_dir   <= reg_wdata[3];
      end
      if (reg_wr && reg_addr == 2'd2) tbl_ptr <= {reg_wdata[31:2], 2'b00};
      if (reg_wr && reg_addr == 2'd1) begin
        if (reg_wdata[1]) st_err <= 1'b0;
        if (reg_wdata[2]) st_int <= 1'b0;
      end
      if (halt) begin
        st <= S_IDLE;
      end else if (go) begin
        st   <= S_FD0;
        dptr <= tbl_ptr;
      end else if (busy && beat && mem_err) begin
        st_err <= 1'b1;
        st     <= S_IDLE;
      end else if (busy && dev_done) begin
        st_err <= 1'b1;
        st     <= S_IDLE;
      end else if (ok) begin
        case (st)
          S_FD0: begin
            cur <= mem_rdata;
            st  <= S_FD1;
          end
          S_FD1: begin
            left     <= {mem_rdata[15:0] == 16'd0, mem_rdata[15:0]};
            last_rgn <= mem_rdata[31];
            dptr     <= dptr + 32'd8;
            st       <= S_XFER;
          end
          default: begin
            cur  <= cur + 32'd1;
            left <= left - 17'd1;
            if (left == 17'd1) begin
              if (last_rgn) begin
                st_int <= 1'b1;
                st     <= S_IDLE;
              end else begin
                st <= S_FD0;
              end
            end
          end
        endcase
      end
    end
  end
endmodule

module prd_dma_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        bm_en,
  input logic        reg_wr,
  input logic [1:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_word,
  input logic [31:0] mem_addr,
  input logic        mem_ack,
  input logic        mem_err,
  input logic        irq
);
  p_bm_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> bm_en);
  p_fetch_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_word) |-> (mem_addr[1:0] == 2'b00 && !mem_we));
  p_stop_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0 && !reg_wdata[0]) |=> !mem_req);
  p_err_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && mem_err) |=> !mem_req);
  p_eot_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !mem_req);
  p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1 && reg_wdata[2] && !mem_req) |=> !irq);
endmodule

bind prd_dma_engine prd_dma_checker u_prd_dma_checker (
  .clk(clk), .rst_n(rst_n), .bm_en(bm_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word),
  .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_err(mem_err), .irq(irq)
);

// File: tb/prd_dma_engine_bench.sv
module prd_dma_engine_bench;
  logic clk = 0, rst_n = 0, bm_en = 1, reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, mem_addr, mem_rdata;
  logic mem_req, mem_we, mem_word, mem_ack, mem_err;
  logic [7:0] mem_wdata, dev_out_data;
  logic [7:0] dev_byte = 8'h10;
  logic dev_in_ready, dev_out_valid, dev_out_ready = 1, dev_done = 0, irq;
  logic err_on = 0;
  logic [31:0] err_addr = 0;
  logic [31:0] tbl [0:63];
  int nb = 0, nf = 0, no = 0, errors = 0, checks = 0;
  logic [31:0] flog [0:7];
  logic [31:0] alog [0:31];
  logic [7:0]  dlog [0:31];
  logic [7:0]  olog [0:31];
  logic [31:0] last_addr;

  always #2 clk = ~clk;

  assign mem_ack   = mem_req;
  assign mem_err   = mem_req && err_on && mem_addr == err_addr;
  assign mem_rdata = mem_word ? tbl[mem_addr[7:2]] : {24'd0, mem_addr[7:0] ^ 8'h5A};

  prd_dma_engine u_prd_dma_engine (.*, .dev_in_valid(1'b1), .dev_in_data(dev_byte));

  always @(negedge clk) begin
    if (mem_req && mem_ack && !mem_err) begin
      if (mem_word) begin
        if (nf < 8) flog[nf] = mem_addr;
        nf++;
      end else begin
        if (nb < 32) begin
          alog[nb] = mem_addr;
          dlog[nb] = mem_we ? mem_wdata : mem_rdata[7:0];
        end
        last_addr = mem_addr;
        nb++;
      end
    end
    if (dev_out_valid && dev_out_ready) begin
      if (no < 32) olog[no] = dev_out_data;
      no++;
    end
    if (dev_in_ready) dev_byte = dev_byte + 8'd1;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++; checks++;
      $display("FAIL watchdog: act=%0d cycles exp=finish", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit c, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!c) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 100000 && !irq; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic prep();
    wr(0, 0); wr(1, 32'h6);
    nb = 0; nf = 0; no = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 3; a++) begin
      rd(a[1:0], v);
      chk(v == 0, "R10 reset reg", v, 0);
    end
    chk(!irq && !mem_req, "R10 reset irq/req", {irq, mem_req}, 0);
  endtask

  task automatic t_two_regions();
    logic [31:0] v;
    prep();
    tbl[16] = 32'h1000; tbl[17] = 32'h0000_0005;
    tbl[18] = 32'h2000; tbl[19] = 32'h8000_0003;
    wr(2, 32'h43);
    rd(2, v); chk(v == 32'h40, "R1 pointer low bits", v, 32'h40);
    wr(0, 32'h9);
    wait_irq();
    chk(nf == 4, "R1 fetch count", nf, 4);
    chk(flog[0] == 32'h40 && flog[1] == 32'h44, "R1 first fetch", flog[1], 32'h44);
    chk(flog[2] == 32'h48 && flog[3] == 32'h4C, "R1 second fetch", flog[3], 32'h4C);
    chk(nb == 8, "R3 beat count", nb, 8);
    for (int i = 0; i < 8; i++) begin
      logic [31:0] ea;
      ea = (i < 5) ? 32'h1000 + i : 32'h2000 + i - 5;
      chk(alog[i] == ea, "R3 write address", alog[i], ea);
      chk(dlog[i] == dlog[0] + i[7:0], "R3 write data order", dlog[i], dlog[0] + i[7:0]);
    end
    rd(1, v); chk(v == 32'h4 && irq, "R4 status after table end", v, 32'h4);
    repeat (10) @(negedge clk);
    chk(nf == 4 && nb == 8, "R4 quiet after end", nf, 4);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wr(1, 32'h2);
    rd(1, v); chk(v == 32'h4 && irq, "R6 write of 0 keeps intr", v, 32'h4);
    wr(1, 32'h4);
    rd(1, v); chk(v == 0 && !irq, "R6 write of 1 clears intr", v, 0);
  endtask

  task automatic t_restart();
    wr(0, 32'h9);
    repeat (10) @(negedge clk);
    chk(nf == 4, "R10 rewrite of set start ignored", nf, 4);
    prep();
    wr(0, 32'h9);
    wait_irq();
    chk(nf == 4 && nb == 8, "R10 new start runs", nb, 8);
  endtask

  task automatic t_read_dir();
    prep();
    tbl[20] = 32'h3000; tbl[21] = 32'h8000_0004;
    wr(2, 32'h50);
    wr(0, 32'h1);
    wait_irq();
    chk(no == 4, "R3 device output count", no, 4);
    for (int i = 0; i < 4; i++)
      chk(olog[i] == (8'(i) ^ 8'h5A), "R3 device output order", olog[i], 8'(i) ^ 8'h5A);
  endtask

  task automatic t_zero_len();
    prep();
    tbl[22] = 32'h10000; tbl[23] = 32'h8000_0000;
    wr(2, 32'h58);
    wr(0, 32'h9);
    wait_irq();
    chk(nb == 65536, "R2 zero count is 64 KiB", nb, 65536);
    chk(last_addr == 32'h1FFFF, "R2 last address", last_addr, 32'h1FFFF);
  endtask

  task automatic t_stop();
    logic [31:0] v;
    int n;
    prep();
    tbl[24] = 32'h4000; tbl[25] = 32'h8000_0064;
    wr(2, 32'h60);
    wr(0, 32'h9);
    repeat (10) @(negedge clk);
    wr(0, 0);
    n = nb;
    repeat (20) @(negedge clk);
    chk(nb == n && nb < 100, "R5 no beats after stop", nb, n);
    rd(1, v); chk(v == 0 && !irq, "R5 status after stop", v, 0);
  endtask

  task automatic t_bm();
    prep();
    bm_en = 0;
    wr(2, 32'h50);
    wr(0, 32'h9);
    repeat (10) @(negedge clk);
    chk(nf == 0 && nb == 0, "R7 no access without enable", nf, 0);
    bm_en = 1;
    wait_irq();
    chk(nb == 4 && irq, "R7 resumes after enable", nb, 4);
  endtask

  task automatic t_memerr();
    logic [31:0] v;
    prep();
    tbl[26] = 32'h5000; tbl[27] = 32'h8000_0010;
    err_on = 1; err_addr = 32'h5002;
    wr(2, 32'h68);
    wr(0, 32'h9);
    repeat (30) @(negedge clk);
    err_on = 0;
    chk(nb == 2, "R8 beats before error", nb, 2);
    rd(1, v); chk(v == 32'h2 && !irq, "R8 status after error", v, 32'h2);
  endtask

  task automatic t_devdone();
    logic [31:0] v;
    int n;
    prep();
    wr(2, 32'h68);
    wr(0, 32'h9);
    repeat (6) @(negedge clk);
    dev_done = 1; @(negedge clk); dev_done = 0;
    n = nb;
    repeat (10) @(negedge clk);
    chk(nb == n && nb < 16, "R9 halt on early completion", nb, n);
    rd(1, v); chk(v == 32'h2, "R9 error status", v, 32'h2);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) tbl[i] = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_reset();
    t_two_regions();
    t_w1c();
    t_restart();
    t_read_dir();
    t_stop();
    t_bm();
    t_memerr();
    t_devdone();
    t_zero_len();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule